// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block gives a 16-bit datapath read and write reach into a program memory whose words are 24 bits wide. The memory is presented as two 16-bit spaces at the same addresses. The low space covers bits 15:0 of each program word. The high space covers bits 23:16 in its lower byte, and its upper byte is a phantom byte with no storage behind it. An 8-bit page register sits above a 16-bit offset to address the memory. Bits 15:1 of the offset pick the word, and bit 0 picks the byte in byte mode.

A request carries a direction, a space (low or high), a size (byte or word), the offset and the write data. The block takes a request only while it is idle. It stays busy for five cycles and then pulses a response. Reads are issued once to a synchronous program-array port and return data one cycle later. Writes never reach the array. Each write produces a single strobe to a set of holding write latches, with a three-bit byte mask over the 24-bit word. A later programming step, outside this block, commits the latches.

Top module: `tbl_access_unit`

## Requirements
- R1: After reset, `page_rdata` is 0, `busy` is 0 and `rsp_valid` is 0.
- R2: A `page_we` pulse loads `page_wdata` into the 8-bit page register on the next clock edge. `page_rdata` returns the page in bits 7:0, and bits 15:8 always read 0.
- R3: The program word address on `mem_addr` and `latch_addr` is {page, offset[15:1]}. The page used is the value the page register held when the request was accepted, so a page write during an access does not change that access.
- R4: A low-space read returns program bits 15:0 in word mode, which ignores offset bit 0. In byte mode it returns {8'h00, bits 7:0} when offset bit 0 = 0 and {8'h00, bits 15:8} when offset bit 0 = 1.
- R5: A high-space read returns {8'h00, bits 23:16} in word mode, and also in byte mode with offset bit 0 = 0. A high byte read with offset bit 0 = 1 addresses the phantom byte and returns 0.
- R6: A request is accepted on a clock edge where `req_valid`=1 and `busy`=0. `busy` is then 1 for exactly five cycles. `rsp_valid` is a one-cycle pulse in the cycle `busy` falls. A read asserts `mem_rd` exactly once, in the first busy cycle.
- R7: While `busy` is 1, `req_valid` is ignored. No second access starts, and `busy` stays 0 after the response if no new request is presented.
- R8: A low-space write pulses `latch_we` once, in the first busy cycle. Word mode gives mask 3'b011 with `req_wdata[15:0]` in bits 15:0. Byte mode gives mask 3'b001 with `req_wdata[7:0]` in bits 7:0 when offset bit 0 = 0, and mask 3'b010 with `req_wdata[7:0]` in bits 15:8 when offset bit 0 = 1. Unmasked bits of `latch_wdata` are 0.
- R9: A high-space write in word mode, or in byte mode with offset bit 0 = 0, gives mask 3'b100 with `req_wdata[7:0]` in bits 23:16. A high byte write with offset bit 0 = 1 targets the phantom byte and never asserts `latch_we`.
- R10: A write never asserts `mem_rd`, and its response carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_we | input | 1 | Load the page register |
| page_wdata | input | 8 | New page value |
| page_rdata | output | 16 | Page register read view |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_high | input | 1 | 1 = high space, 0 = low space |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_offset | input | 16 | Offset within the page; bit 0 selects the byte |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | Access complete, one cycle |
| rsp_rdata | output | 16 | Read result |
| mem_rd | output | 1 | Program array read strobe |
| mem_addr | output | 23 | Program array word address |
| mem_rdata | input | 24 | Program array data, valid the cycle after `mem_rd` |
| latch_we | output | 1 | Write-latch strobe |
| latch_addr | output | 23 | Write-latch word address |
| latch_wdata | output | 24 | Write-latch data |
| latch_wmask | output | 3 | Byte mask over the 24-bit word |

## Verification
Directed accesses cover every pairing of space, size and byte select, for both reads and writes. This separates the two phantom cases from the byte lanes that do have storage. It also shows whether word mode really ignores offset bit 0. A page write placed inside an access tells a captured address apart from one sampled live. A request presented in mid-access tells an ignored request apart from a queued one. After these, several hundred seeded random accesses mix pages, offsets, modes and data. Every word of the array model holds a distinct pattern, so a wrong byte lane or a wrong address bit yields a visibly wrong value.

// File: rtl/tbl_access_unit.sv
module tbl_access_unit #(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 16,
  parameter int ACC_CYCLES = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     page_we,
  input  logic [PAGE_W-1:0]        page_wdata,
  output logic [15:0]              page_rdata,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_high,
  input  logic                     req_byte,
  input  logic [OFS_W-1:0]         req_offset,
  input  logic [15:0]              req_wdata,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [15:0]              rsp_rdata,
  output logic                     mem_rd,
  output logic [PAGE_W+OFS_W-2:0]  mem_addr,
  input  logic [23:0]              mem_rdata,
  output logic                     latch_we,
  output logic [PAGE_W+OFS_W-2:0]  latch_addr,
  output logic [23:0]              latch_wdata,
  output logic [2:0]               latch_wmask
);
  localparam int ADDR_W = PAGE_W + OFS_W - 1;
  localparam int CNT_W  = $clog2(ACC_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_CYCLES - 1);

  logic [PAGE_W-1:0] page_q;
  logic              busy_q, rsp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q, hi_q, by_q, lsb_q;
  logic [15:0]       wd_q, rdata_q, rd_fmt;
  logic [23:0]       word_q;

  wire accept  = req_valid & ~busy_q;
  wire first   = busy_q & (cnt_q == '0);
  wire last    = busy_q & (cnt_q == LAST);
  wire phantom = hi_q & by_q & lsb_q;

  assign page_rdata = 16'(page_q);
  assign busy       = busy_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign mem_rd     = first & ~wr_q;
  assign mem_addr   = a_q;
  assign latch_we   = first & wr_q & ~phantom;
  assign latch_addr = a_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       page_q <= '0;
    else if (page_we) page_q <= page_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rsp_q <= 1'b0; cnt_q <= '0; a_q <= '0;
      wr_q <= 1'b0; hi_q <= 1'b0; by_q <= 1'b0; lsb_q <= 1'b0;
      wd_q <= '0; rdata_q <= '0; word_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        a_q    <= {page_q, req_offset[OFS_W-1:1]};
        wr_q   <= req_write;
        hi_q   <= req_high;
        by_q   <= req_byte;
        lsb_q  <= req_offset[0];
        wd_q   <= req_wdata;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1) && !wr_q) word_q <= mem_rdata;
        if (last) begin
          busy_q  <= 1'b0;
          rsp_q   <= 1'b1;
          rdata_q <= wr_q ? 16'h0000 : rd_fmt;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    if (!hi_q)
      rd_fmt = !by_q ? word_q[15:0] : (lsb_q ? {8'h00, word_q[15:8]} : {8'h00, word_q[7:0]});
    else
      rd_fmt = phantom ? 16'h0000 : {8'h00, word_q[23:16]};
  end

  always_comb begin
    latch_wmask = 3'b000;
    latch_wdata = 24'h000000;
    if (!hi_q) begin
      if (!by_q) begin
        latch_wmask = 3'b011; latch_wdata = {8'h00, wd_q};
      end else if (lsb_q) begin
        latch_wmask = 3'b010; latch_wdata = {8'h00, wd_q[7:0], 8'h00};
      end else begin
        latch_wmask = 3'b001; latch_wdata = {16'h0000, wd_q[7:0]};
      end
    end else if (!phantom) begin
      latch_wmask = 3'b100; latch_wdata = {wd_q[7:0], 16'h0000};
    end
  end

  // R6
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && cnt_q == '0);
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> busy_q);
  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy && $past(busy_q));
  // R6
  single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q != '0 |-> $stable(a_q) && $stable(wr_q));
  // R5
  phantom_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !wr_q && phantom |-> rsp_rdata == 16'h0000);
  // R9
  phantom_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && phantom |-> !latch_we);
  // R10
  wr_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_q |-> !mem_rd);
endmodule

// File: tb/test_tbl_access_unit.sv
module test_tbl_access_unit;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic page_we = 0; logic [7:0] page_wdata = 0; logic [15:0] page_rdata;
  logic req_valid = 0, req_write = 0, req_high = 0, req_byte = 0;
  logic [15:0] req_offset = 0, req_wdata = 0;
  logic busy, rsp_valid, mem_rd, latch_we;
  logic [15:0] rsp_rdata;
  logic [22:0] mem_addr, latch_addr;
  logic [23:0] mem_rdata = 0, latch_wdata;
  logic [2:0] latch_wmask;
  int errors = 0, checks = 0;
  logic [7:0] pg = 0;

  always #(PERIOD/2) clk = ~clk;

  tbl_access_unit i_tbl_access_unit (.*);

  function automatic logic [23:0] fmem(logic [22:0] a);
    logic [31:0] x = 32'(a) * 32'h9E3779B1;
    return 24'(x ^ (32'(a) << 3) ^ 32'h005A5A5A);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

  function automatic logic [15:0] exp_rd(logic [23:0] w, bit hi, bit by, bit lsb);
    if (!hi) return !by ? w[15:0] : (lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
    return (by && lsb) ? 16'h0000 : {8'h00, w[23:16]};
  endfunction

  function automatic logic [2:0] exp_mask(bit hi, bit by, bit lsb);
    if (hi) return (by && lsb) ? 3'b000 : 3'b100;
    return !by ? 3'b011 : (lsb ? 3'b010 : 3'b001);
  endfunction

  function automatic logic [23:0] exp_wd(bit hi, bit by, bit lsb, logic [15:0] d);
    case (exp_mask(hi, by, lsb))
      3'b011:  return {8'h00, d};
      3'b010:  return {8'h00, d[7:0], 8'h00};
      3'b001:  return {16'h0000, d[7:0]};
      3'b100:  return {d[7:0], 16'h0000};
      default: return 24'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_page(logic [7:0] p);
    @(negedge clk); page_we = 1; page_wdata = p;
    @(negedge clk); page_we = 0; pg = p;
  endtask

  task automatic access(bit wr, bit hi, bit by, logic [15:0] ofs, logic [15:0] wd,
                        bit poke_busy, bit poke_page, logic [7:0] newpg);
    logic [22:0] ea = {pg, ofs[15:1]};
    int nb = 0, nrd = 0, nlw = 0, early_rsp = 0;
    logic [22:0] rda = 0, lwa = 0;
    logic [23:0] lwd = 0; logic [2:0] lwm = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_high = hi; req_byte = by;
    req_offset = ofs; req_wdata = wd;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i < 5) begin
        if (busy) nb++;
        if (rsp_valid) early_rsp++;
        if (mem_rd) begin nrd++; rda = mem_addr; end
        if (latch_we) begin nlw++; lwa = latch_addr; lwd = latch_wdata; lwm = latch_wmask; end
      end
      req_valid = 0;
      if (poke_busy && i == 1) begin
        req_valid = 1; req_write = ~wr; req_high = ~hi; req_offset = ~ofs;
      end
      if (poke_page && i == 0) begin page_we = 1; page_wdata = newpg; end
      if (poke_page && i == 1) begin page_we = 0; pg = newpg; end
      if (i == 5) begin
        chk(rsp_valid && !busy && early_rsp == 0, "R6", "response at sixth cycle",
            {early_rsp[15:0], 14'h0, rsp_valid, busy}, 32'h2);
        if (wr)
          chk(rsp_rdata == 16'h0, "R10", "write response data", rsp_rdata, 0);
        else
          chk(rsp_rdata == exp_rd(fmem(ea), hi, by, ofs[0]), hi ? "R5" : "R4",
              "read data", rsp_rdata, exp_rd(fmem(ea), hi, by, ofs[0]));
      end
    end
    chk(nb == 5, "R6", "busy cycles", nb, 5);
    if (!wr) begin
      chk(nrd == 1, "R6", "one array read", nrd, 1);
      chk(rda == ea, "R3", "read address", rda, ea);
    end else begin
      chk(nrd == 0, "R10", "no array read on write", nrd, 0);
      if (hi && by && ofs[0])
        chk(nlw == 0, "R9", "phantom write suppressed", nlw, 0);
      else begin
        chk(nlw == 1, hi ? "R9" : "R8", "one latch strobe", nlw, 1);
        chk(lwa == ea, "R3", "latch address", lwa, ea);
        chk(lwm == exp_mask(hi, by, ofs[0]), hi ? "R9" : "R8", "latch mask",
            lwm, exp_mask(hi, by, ofs[0]));
        chk(lwd == exp_wd(hi, by, ofs[0], wd), hi ? "R9" : "R8", "latch data",
            lwd, exp_wd(hi, by, ofs[0], wd));
      end
    end
    if (poke_busy) begin
      @(negedge clk);
      chk(!busy && !mem_rd && !latch_we, "R7", "mid-access request ignored",
          {busy, mem_rd, latch_we}, 0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk(page_rdata == 0 && !busy && !rsp_valid, "R1", "reset state",
        {page_rdata, 14'h0, busy, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(page_rdata == 0 && !busy && !rsp_valid, "R1", "idle after reset",
        {page_rdata, 14'h0, busy, rsp_valid}, 0);
    set_page(8'hFF);
    chk(page_rdata == 16'h00FF, "R2", "page readback, upper bits zero", page_rdata, 16'h00FF);
    set_page(8'h5C);
    chk(page_rdata == 16'h005C, "R2", "page readback", page_rdata, 16'h005C);
    // R4 R5 R8 R9: every space, size and byte-select pairing
    for (int m = 0; m < 16; m++)
      access(m[3], m[2], m[1], {15'h2A71, m[0]}, 16'hC3A5 ^ 16'(m), 0, 0, 0);
    // R3: page changed mid-access does not alter address
    access(0, 0, 0, 16'h1234, 0, 0, 1, 8'h11);
    chk(page_rdata == 16'h0011, "R3", "new page after access", page_rdata, 16'h0011);
    access(1, 1, 0, 16'hFFFF, 16'h00EE, 0, 1, 8'h22);
    access(0, 1, 0, 16'h0000, 0, 0, 0, 0);
    // R7: requests during busy ignored
    access(0, 0, 1, 16'h8001, 0, 1, 0, 0);
    access(1, 0, 0, 16'h4444, 16'hBEEF, 1, 0, 0);
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) set_page(8'($urandom));
      access(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
             ($urandom % 16) == 0, ($urandom % 16) == 0, 8'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule